// File: doc/BRIEF.md
# Single-Operand Accumulator Processor Core

This block is a small 8-bit processor core. Each instruction names one 16-bit absolute memory address and nothing else. For arithmetic, the accumulator is always one source and always receives the result. The store instruction turns the direction around: the accumulator is the source and the named address is the destination. Instructions and data share one byte-wide memory port. Every memory access holds the address and a strobe for two clock cycles.

An instruction is three bytes in this order: opcode, address low byte, address high byte. The core runs a fixed sequence for each instruction, built from these states:

- ST_OPC fetches the opcode.
- ST_ALO and ST_AHI fetch the two address bytes.
- ST_RD reads the operand.
- ST_EX is a one-cycle execute step.
- ST_WR writes the accumulator out.
- ST_HALT stops the core.

The transitions are:

- ST_OPC goes to ST_ALO, or to ST_HALT for the stop code.
- ST_ALO goes to ST_AHI.
- ST_AHI goes to ST_RD for reading opcodes, to ST_WR for a store, and back to ST_OPC for any other code.
- ST_RD goes to ST_EX.
- ST_EX goes to ST_OPC.
- ST_WR goes to ST_OPC.
- ST_HALT loops on itself.

The core has a zero flag and a carry flag. There are no branches, so a program runs straight through from address 0 until it reaches the stop code.

Top module: `acc_core`

## Requirements
- R1: While reset is held and right after it is released, the outputs are as follows. The accumulator reads 0. Zero, carry and halted read 0. mem_rd is 1 with mem_addr 0, because the first opcode fetch is already presented.
- R2: Instruction fetch works as follows.
  - Each byte access lasts two cycles, with mem_addr and mem_rd held steady.
  - mem_rdata is taken at the end of the second cycle.
  - The three instruction bytes come from consecutive addresses, starting at the program counter, in the order opcode, address low, address high.
  - The program counter starts at 0 and advances by one per byte.
- R3: Opcode 0x10 loads the byte at the named address into the accumulator.
  - It takes 9 cycles: 6 fetch, 2 operand read, then 1 execute cycle with no access.
  - The zero flag is set from the new value.
  - Carry is left unchanged.
  - The new accumulator value is visible from the first cycle of the next instruction.
- R4: Opcode 0x11 writes the accumulator to the named address.
  - It takes 8 cycles: 6 fetch, then 2 cycles of mem_wr with mem_wdata equal to the accumulator.
  - The accumulator and both flags are unchanged.
- R5: Opcode 0x12 adds the memory byte to the accumulator, modulo 256.
  - Carry is set to the carry out of bit 7.
  - Zero is set from the result.
  - Timing is the same as R3.
- R6: Opcode 0x13 subtracts the memory byte from the accumulator, modulo 256.
  - Carry is set to 1 when a borrow occurs (accumulator less than the operand).
  - Zero is set from the result.
  - Timing is the same as R3.
- R7: Opcode 0x14 multiplies the accumulator by the memory byte.
  - The accumulator keeps the low 8 bits of the product.
  - Carry is set when the high byte of the product is nonzero.
  - Zero is set from the low byte.
  - Timing is the same as R3.
- R8: Opcode 0xFF stops the core after its two-cycle opcode fetch. From the next cycle onward:
  - halted stays 1 until reset;
  - mem_rd and mem_wr stay 0;
  - the accumulator and flags no longer change.
- R9: Any other opcode value has no effect beyond its fetch.
  - All three instruction bytes are fetched (6 cycles).
  - Execution then moves straight to the next instruction.
  - There is no data access, and the accumulator and flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 16 | Memory address, valid while mem_rd or mem_wr is high |
| mem_rd | output | 1 | Read strobe, high for both cycles of a read access |
| mem_wr | output | 1 | Write strobe, high for both cycles of a write access |
| mem_wdata | output | 8 | Write data; the accumulator value |
| mem_rdata | input | 8 | Read data, required valid in the second cycle of a read |
| acc_out | output | 8 | Accumulator contents |
| zero | output | 1 | Zero flag |
| carry | output | 1 | Carry / borrow / product-overflow flag |
| halted | output | 1 | High once the stop code has been fetched |

## Verification
The assertions take two things for granted about the memory:

- It returns the addressed byte within the two-cycle access window.
- The data it returns does not depend on any timing other than the held address.

The bench memory meets both conditions with an asynchronous read array and a write on each clock edge where mem_wr is high.

The stimulus programs have three further properties:

- No program writes over its own instruction bytes.
- Every program ends in the stop code.
- Operand values are chosen to hit the carry, borrow, zero and product-overflow boundaries and the topmost address.

Because of this, the bench model can read its own copy of memory when it predicts each bus cycle.

// File: rtl/acc_pkg.sv
package acc_pkg;

    typedef enum logic [7:0] {
        OP_LOAD = 8'h10,
        OP_STO  = 8'h11,
        OP_ADD  = 8'h12,
        OP_SUB  = 8'h13,
        OP_MUL  = 8'h14,
        OP_HALT = 8'hFF
    } opcode_e;

    typedef enum logic [2:0] {
        ST_OPC,
        ST_ALO,
        ST_AHI,
        ST_RD,
        ST_EX,
        ST_WR,
        ST_HALT
    } state_e;

    function automatic logic needs_operand(input logic [7:0] op);
        return (op == OP_LOAD) || (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL);
    endfunction

    function automatic logic is_store(input logic [7:0] op);
        return op == OP_STO;
    endfunction

endpackage

// File: rtl/acc_seq.sv
module acc_seq
    import acc_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          exec_en,
    output logic [7:0]    op,
    output logic [DW-1:0] opnd,
    output logic          halted
);

    localparam int AHI_W = AW - DW;

    state_e        state;
    logic          phase;
    logic [AW-1:0] pc;
    logic [AW-1:0] ea;
    logic [7:0]    ir;
    logic [DW-1:0] opnd_q;

    // State register and transitions; phase marks the second cycle of an access.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_OPC;
            phase  <= 1'b0;
            pc     <= '0;
            ea     <= '0;
            ir     <= '0;
            opnd_q <= '0;
        end else begin
            unique case (state)
                ST_OPC: begin
                    phase <= ~phase;
                    if (phase) begin
                        ir    <= rdata[7:0];
                        pc    <= pc + AW'(1);
                        state <= (rdata[7:0] == OP_HALT) ? ST_HALT : ST_ALO;
                    end
                end
                ST_ALO: begin
                    phase <= ~phase;
                    if (phase) begin
                        ea[DW-1:0] <= rdata;
                        pc         <= pc + AW'(1);
                        state      <= ST_AHI;
                    end
                end
                ST_AHI: begin
                    phase <= ~phase;
                    if (phase) begin
                        ea[AW-1:DW] <= rdata[AHI_W-1:0];
                        pc          <= pc + AW'(1);
                        if (needs_operand(ir))
                            state <= ST_RD;
                        else if (is_store(ir))
                            state <= ST_WR;
                        else
                            state <= ST_OPC;
                    end
                end
                ST_RD: begin
                    phase <= ~phase;
                    if (phase) begin
                        opnd_q <= rdata;
                        state  <= ST_EX;
                    end
                end
                ST_EX: begin
                    state <= ST_OPC;
                end
                ST_WR: begin
                    phase <= ~phase;
                    if (phase)
                        state <= ST_OPC;
                end
                ST_HALT: begin
                    state <= ST_HALT;
                end
                default: begin
                    state <= ST_OPC;
                    phase <= 1'b0;
                end
            endcase
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        mem_addr = '0;
        mem_rd   = 1'b0;
        mem_wr   = 1'b0;
        exec_en  = 1'b0;
        halted   = 1'b0;
        unique case (state)
            ST_OPC, ST_ALO, ST_AHI: begin
                mem_addr = pc;
                mem_rd   = 1'b1;
            end
            ST_RD: begin
                mem_addr = ea;
                mem_rd   = 1'b1;
            end
            ST_WR: begin
                mem_addr = ea;
                mem_wr   = 1'b1;
            end
            ST_EX:   exec_en = 1'b1;
            ST_HALT: halted  = 1'b1;
            default: ;
        endcase
    end

    assign op   = ir;
    assign opnd = opnd_q;

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [7:0]    op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] res,
    output logic          cout,
    output logic          upd_acc,
    output logic          upd_c
);

    logic [DW:0]     sum;
    logic [DW:0]     diff;
    logic [2*DW-1:0] prod;

    always_comb begin
        sum  = {1'b0, a} + {1'b0, b};
        diff = {1'b0, a} - {1'b0, b};
        prod = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
        res     = '0;
        cout    = 1'b0;
        upd_acc = 1'b0;
        upd_c   = 1'b0;
        unique case (op)
            OP_LOAD: begin
                res     = b;
                upd_acc = 1'b1;
            end
            OP_ADD: begin
                res     = sum[DW-1:0];
                cout    = sum[DW];
                upd_acc = 1'b1;
                upd_c   = 1'b1;
            end
            OP_SUB: begin
                res     = diff[DW-1:0];
                cout    = diff[DW];
                upd_acc = 1'b1;
                upd_c   = 1'b1;
            end
            OP_MUL: begin
                res     = prod[DW-1:0];
                cout    = |prod[2*DW-1:DW];
                upd_acc = 1'b1;
                upd_c   = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/acc_dp.sv
module acc_dp #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          exec_en,
    input  logic          upd_acc,
    input  logic          upd_c,
    input  logic [DW-1:0] res,
    input  logic          cout,
    output logic [DW-1:0] acc,
    output logic          zero,
    output logic          carry
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc   <= '0;
            zero  <= 1'b0;
            carry <= 1'b0;
        end else if (exec_en && upd_acc) begin
            acc  <= res;
            zero <= (res == '0);
            if (upd_c)
                carry <= cout;
        end
    end

endmodule

// File: rtl/acc_core.sv
module acc_core #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] acc_out,
    output logic          zero,
    output logic          carry,
    output logic          halted
);

    logic          exec_en;
    logic [7:0]    op;
    logic [DW-1:0] opnd;
    logic [DW-1:0] res;
    logic          cout;
    logic          upd_acc;
    logic          upd_c;

    acc_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rdata    (mem_rdata),
        .mem_addr (mem_addr),
        .mem_rd   (mem_rd),
        .mem_wr   (mem_wr),
        .exec_en  (exec_en),
        .op       (op),
        .opnd     (opnd),
        .halted   (halted)
    );

    acc_alu #(.DW(DW)) u_alu (
        .op      (op),
        .a       (acc_out),
        .b       (opnd),
        .res     (res),
        .cout    (cout),
        .upd_acc (upd_acc),
        .upd_c   (upd_c)
    );

    acc_dp #(.DW(DW)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .exec_en (exec_en),
        .upd_acc (upd_acc),
        .upd_c   (upd_c),
        .res     (res),
        .cout    (cout),
        .acc     (acc_out),
        .zero    (zero),
        .carry   (carry)
    );

    assign mem_wdata = acc_out;

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [DW-1:0] mem_wdata,
    input logic [DW-1:0] acc_out,
    input logic          halted
);

    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    a_r4_write_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr) |=> mem_wr && $stable(mem_addr) && $stable(mem_wdata));

    a_r4_store_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> $stable(acc_out));

    a_r3_acc_after_exec: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(acc_out) |-> $past(!mem_rd && !mem_wr));

    a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    a_r8_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_rd && !mem_wr);

endmodule

bind acc_core acc_core_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sim_acc_core.sv
module sim_acc_core;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic        mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic [7:0]  acc_out;
    logic        zero;
    logic        carry;
    logic        halted;

    always #5 clk = ~clk;

    logic [7:0] mem  [0:65535];
    logic [7:0] mmod [0:65535];

    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;

    acc_core u0 (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .acc_out(acc_out), .zero(zero), .carry(carry), .halted(halted)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    task automatic chk(input bit ok, input int req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference: one expected bus/state record per clock cycle.
    typedef struct {
        bit rd; bit wr; int addr; int wdata;
        int acc; bit z; bit c; bit h; int req; int sreq;
    } cyc_t;

    cyc_t q[$];
    cyc_t e;
    int   m_pc, m_acc, m_sreq;
    bit   m_z, m_c, m_h;

    task automatic push(input bit rd, input bit wr, input int a, input int wd, input int req);
        cyc_t c;
        c.rd = rd; c.wr = wr; c.addr = a; c.wdata = wd;
        c.acc = m_acc; c.z = m_z; c.c = m_c; c.h = m_h; c.req = req; c.sreq = m_sreq;
        q.push_back(c);
    endtask

    task automatic build();
        int op, ea, b, r;
        if (m_h) begin
            push(0, 0, 0, 0, 8);
            return;
        end
        op = mmod[m_pc];
        push(1, 0, m_pc, 0, 2); push(1, 0, m_pc, 0, 2);
        if (op == 8'hFF) begin
            m_h = 1; m_pc = (m_pc + 1) & 16'hFFFF; m_sreq = 8;
            return;
        end
        push(1, 0, (m_pc + 1) & 16'hFFFF, 0, 2); push(1, 0, (m_pc + 1) & 16'hFFFF, 0, 2);
        push(1, 0, (m_pc + 2) & 16'hFFFF, 0, 2); push(1, 0, (m_pc + 2) & 16'hFFFF, 0, 2);
        ea = mmod[(m_pc + 1) & 16'hFFFF] | (int'(mmod[(m_pc + 2) & 16'hFFFF]) << 8);
        m_pc = (m_pc + 3) & 16'hFFFF;
        case (op)
            8'h10, 8'h12, 8'h13, 8'h14: begin
                r = (op == 8'h10) ? 3 : (op == 8'h12) ? 5 : (op == 8'h13) ? 6 : 7;
                push(1, 0, ea, 0, r); push(1, 0, ea, 0, r); push(0, 0, 0, 0, r);
                b = mmod[ea];
                case (op)
                    8'h10: m_acc = b;
                    8'h12: begin m_c = (m_acc + b) > 255; m_acc = (m_acc + b) & 255; end
                    8'h13: begin m_c = m_acc < b; m_acc = (m_acc - b) & 255; end
                    default: begin m_c = (m_acc * b) > 255; m_acc = (m_acc * b) & 255; end
                endcase
                m_z = (m_acc == 0); m_sreq = r;
            end
            8'h11: begin
                push(0, 1, ea, m_acc, 4); push(0, 1, ea, m_acc, 4);
                mmod[ea] = m_acc[7:0];
            end
            default: ; // R9: fetch only
        endcase
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            q.delete();
            m_pc = 0; m_acc = 0; m_z = 0; m_c = 0; m_h = 0; m_sreq = 1;
            // R1: reset values and first fetch presented
            chk(acc_out == 8'h00, 1, "reset acc", acc_out, 0);
            chk(zero == 1'b0 && carry == 1'b0, 1, "reset flags", {zero, carry}, 0);
            chk(halted == 1'b0, 1, "reset halted", halted, 0);
            chk(mem_rd == 1'b1 && mem_addr == 16'h0000, 1, "reset fetch", {mem_rd, mem_addr}, 17'h10000);
        end else if (!done) begin
            if (q.size() == 0) build();
            e = q.pop_front();
            chk(mem_rd == e.rd, e.req, "mem_rd", mem_rd, e.rd);
            chk(mem_wr == e.wr, e.req, "mem_wr", mem_wr, e.wr);
            if (e.rd || e.wr) chk(mem_addr == e.addr[15:0], e.req, "mem_addr", mem_addr, e.addr);
            if (e.wr) chk(mem_wdata == e.wdata[7:0], e.req, "mem_wdata", mem_wdata, e.wdata);
            chk(acc_out == e.acc[7:0], e.sreq, "acc", acc_out, e.acc);
            chk(zero == e.z, e.sreq, "zero", zero, e.z);
            chk(carry == e.c, e.sreq, "carry", carry, e.c);
            chk(halted == e.h, 8, "halted", halted, e.h);
        end
    end

    task automatic clear_mem();
        for (int i = 0; i < 65536; i++) begin
            mem[i] = 8'h00; mmod[i] = 8'h00;
        end
    endtask

    task automatic poke(input int a, input int d);
        mem[a] = d[7:0]; mmod[a] = d[7:0];
    endtask

    task automatic put(inout int p, input int op, input int a);
        poke(p, op); poke(p + 1, a & 255); poke(p + 2, (a >> 8) & 255);
        p += 3;
    endtask

    task automatic hold_reset();
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    task automatic run();
        @(posedge clk); #1 rst_n = 1'b1;
        while (!halted) @(negedge clk);
        repeat (12) @(negedge clk);
    endtask

    initial begin
        int p;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);

        // Program 1: main arithmetic and store patterns
        clear_mem();
        poke(16'h0100, 8'h05); poke(16'h0101, 8'hFE); poke(16'h0102, 8'h04);
        poke(16'h0103, 8'hFF); poke(16'h0104, 8'h10); poke(16'h0105, 8'h10);
        poke(16'h0106, 8'h0C); poke(16'h0107, 8'h05); poke(16'h0108, 8'h00);
        poke(16'h0109, 8'h01);
        p = 0;
        put(p, 8'h10, 16'h0108);  // R3: load zero sets zero flag
        put(p, 8'h10, 16'h0100);  // R3: load 5
        put(p, 8'h12, 16'h0101);  // R5: 5+FE = 03, carry
        put(p, 8'h13, 16'h0102);  // R6: 03-04 = FF, borrow
        put(p, 8'h13, 16'h0103);  // R6: FF-FF = 00, no borrow
        put(p, 8'h12, 16'h0103);  // R5: 00+FF = FF, no carry
        put(p, 8'h12, 16'h0109);  // R5: FF+01 = 00, carry and zero
        put(p, 8'h10, 16'h0104);  // R3: load keeps carry
        put(p, 8'h14, 16'h0105);  // R7: 10*10 = 0100, low byte 0, carry
        put(p, 8'h10, 16'h0106);
        put(p, 8'h14, 16'h0107);  // R7: 0C*05 = 3C, no carry
        put(p, 8'h11, 16'h0200);  // R4: store 3C
        put(p, 8'h55, 16'h1234);  // R9: unknown opcode, no effect
        put(p, 8'h10, 16'h0108);
        put(p, 8'h10, 16'h0200);  // R4: read back stored byte
        put(p, 8'h11, 16'hABCD);  // R4: store to a high address
        poke(p, 8'hFF);           // R8
        hold_reset();
        run();
        chk(mem[16'h0200] == 8'h3C, 4, "stored byte 0200", mem[16'h0200], 8'h3C);
        chk(mem[16'hABCD] == 8'h3C, 4, "stored byte ABCD", mem[16'hABCD], 8'h3C);
        chk(mem[16'h1234] == 8'h00, 9, "unknown opcode left memory", mem[16'h1234], 0);

        // Program 2: stop code as the very first instruction (R8)
        hold_reset();
        clear_mem();
        poke(0, 8'hFF);
        run();

        // Program 3: topmost address as operand and destination
        hold_reset();
        clear_mem();
        poke(16'hFFFF, 8'h80);
        p = 0;
        put(p, 8'h10, 16'hFFFF);  // R3
        put(p, 8'h12, 16'hFFFF);  // R5: 80+80 = 00, carry
        put(p, 8'h10, 16'hFFFF);
        put(p, 8'h14, 16'hFFFF);  // R7: 80*80 = 4000, low 00, carry
        put(p, 8'h11, 16'hFFFF);  // R4: store 00
        put(p, 8'h10, 16'hFFFF);
        poke(p, 8'hFF);
        run();
        chk(mem[16'hFFFF] == 8'h00, 4, "stored byte FFFF", mem[16'hFFFF], 0);

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL R8 watchdog expired actual=%0h expected=%0h", halted, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule